// File: doc/BRIEF.md
# Radar Pulse Timing Sequencer

This block produces the repeating timing schedule of a pulsed radar. Each pulse period is made of four consecutive intervals: transmit on, transmit-to-receive switching, receive look and inter-pulse idle. Each interval has its own length register. The block drives a transmit-active flag, a receive-window flag, a one-cycle strobe at the start of every pulse, and two switch controls. The switch controls are copies of the transmit and receive flags, each delayed by its own programmable number of clocks, so that external antenna switches and amplifiers can be timed to the pulse.

All settings arrive over a write-only configuration port: a 7-bit address, 32-bit data and a one-cycle write strobe. A hold bit in the mode register keeps the sequencer stopped. Software programs the intervals and delays while held, then clears the bit to start pulsing. Interval lengths are stored as the clock count minus one. Both switch delays share one 32-bit word.

Top module: `radar_pulse_seq`

## Requirements
- R1: A synchronous reset clears the four interval registers and the delay word to zero and sets the hold bit. All outputs stay low until the hold bit is cleared.
- R2: A register takes the value of `cfg_data` on a clock edge where `cfg_we` is high. The addresses are: 0x00 mode (bit 0 is the hold bit), 0x01 on-time, 0x02 switching time, 0x03 look time, 0x04 idle time, 0x05 delay word. Interval registers use data bits 23:0.
- R3: After the write edge that clears the hold bit, the first transmit-on clock begins at the next clock edge.
- R4: The phases repeat in the order on, switch, look, idle. A phase whose register holds N lasts N+1 clocks. `tx_active` is high exactly during on, and `rx_window` is high exactly during look.
- R5: `pulse_start` is high for exactly the first clock of each transmit-on phase and at no other time.
- R6: Interval writes made while pulsing take effect at the next pulse start. The period in progress keeps its old lengths.
- R7: `tx_switch` equals `tx_active` delayed by the transmit delay (delay word bits 31:16) in clocks. This holds even when the delay is longer than the on phase, provided it is shorter than the pulse period.
- R8: `rx_switch` equals `rx_window` delayed by the receive delay (delay word bits 15:0) in clocks, under the same condition.
- R9: A delay of zero makes the switch control follow its flag in the same clock.
- R10: Setting the hold bit while pulsing drives all outputs low from the second clock edge after the write. A later release starts a fresh period from transmit on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_addr | input | 7 | Configuration register address |
| cfg_data | input | 32 | Configuration write data |
| cfg_we | input | 1 | Write strobe, one cycle per write |
| tx_active | output | 1 | High during the transmit-on phase |
| rx_window | output | 1 | High during the receive-look phase |
| pulse_start | output | 1 | One-clock strobe at each pulse start |
| tx_switch | output | 1 | Delayed transmit switch control |
| rx_switch | output | 1 | Delayed receive switch control |

## Verification
A wrong phase counter or a wrong phase transition shows up at once in the flags: a phase boundary lands a clock early or late, or `tx_active` and `rx_window` overlap. If the captured interval lengths are corrupted, the error appears no later than the next pulse start, because the period length and the strobe position move. A fault in a delay counter is seen at the ports only one delay later, as a misplaced switch edge. For that reason the bench runs complete periods with delays both shorter and longer than the on phase.

// File: rtl/radar_pulse_seq.sv
module radar_pulse_seq #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24,
  parameter int DLY_W  = 16,
  parameter logic [ADDR_W-1:0] A_MODE = 'h0,
  parameter logic [ADDR_W-1:0] A_ON   = 'h1,
  parameter logic [ADDR_W-1:0] A_SW   = 'h2,
  parameter logic [ADDR_W-1:0] A_LOOK = 'h3,
  parameter logic [ADDR_W-1:0] A_IDLE = 'h4,
  parameter logic [ADDR_W-1:0] A_DLY  = 'h5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              cfg_we,
  output logic              tx_active,
  output logic              rx_window,
  output logic              pulse_start,
  output logic              tx_switch,
  output logic              rx_switch
);
  localparam int NCH = 2;

  typedef enum logic [2:0] {PH_HOLD, PH_ON, PH_SW, PH_LOOK, PH_IDLE} phase_t;

  logic             hold;
  logic [CNT_W-1:0] on_r, sw_r, look_r, idle_r;
  logic [CNT_W-1:0] on_s, sw_s, look_s, idle_s;
  logic [DATA_W-1:0] dly_r;
  phase_t           phase;
  logic [CNT_W-1:0] cnt, lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= 1'b1;
      on_r <= '0; sw_r <= '0; look_r <= '0; idle_r <= '0;
      dly_r <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_MODE: hold   <= cfg_data[0];
        A_ON:   on_r   <= cfg_data[CNT_W-1:0];
        A_SW:   sw_r   <= cfg_data[CNT_W-1:0];
        A_LOOK: look_r <= cfg_data[CNT_W-1:0];
        A_IDLE: idle_r <= cfg_data[CNT_W-1:0];
        A_DLY:  dly_r  <= cfg_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (phase)
      PH_ON:   lim = on_s;
      PH_SW:   lim = sw_s;
      PH_LOOK: lim = look_s;
      default: lim = idle_s;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      phase <= PH_HOLD;
      cnt   <= '0;
      if (rst) begin
        on_s <= '0; sw_s <= '0; look_s <= '0; idle_s <= '0;
      end
    end else if (phase == PH_HOLD || (phase == PH_IDLE && cnt == lim)) begin
      phase <= PH_ON;
      cnt   <= '0;
      on_s <= on_r; sw_s <= sw_r; look_s <= look_r; idle_s <= idle_r;
    end else if (cnt == lim) begin
      cnt <= '0;
      case (phase)
        PH_ON:   phase <= PH_SW;
        PH_SW:   phase <= PH_LOOK;
        default: phase <= PH_IDLE;
      endcase
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tx_active   = (phase == PH_ON);
  assign rx_window   = (phase == PH_LOOK);
  assign pulse_start = tx_active && (cnt == '0);

  logic [NCH-1:0] act, sw_out;
  assign act = {rx_window, tx_active};

  for (genvar g = 0; g < NCH; g++) begin : g_dly
    logic [DLY_W-1:0] dly, rcnt, fcnt, rn, fn;
    logic act_d, sw_q, rbusy, fbusy, rise, fall, rfire, ffire;

    assign dly   = (g == 0) ? dly_r[2*DLY_W-1:DLY_W] : dly_r[DLY_W-1:0];
    assign rise  = act[g] && !act_d;
    assign fall  = !act[g] && act_d;
    assign rn    = rise ? DLY_W'(1) : rcnt + 1'b1;
    assign fn    = fall ? DLY_W'(1) : fcnt + 1'b1;
    assign rfire = (rise || rbusy) && (rn == dly);
    assign ffire = (fall || fbusy) && (fn == dly);

    always_ff @(posedge clk) begin
      if (rst || hold) begin
        act_d <= 1'b0; sw_q <= 1'b0;
        rbusy <= 1'b0; fbusy <= 1'b0;
        rcnt  <= '0;   fcnt  <= '0;
      end else begin
        act_d <= act[g];
        if (rise || rbusy) begin
          rcnt  <= rn;
          rbusy <= (dly != '0) && !rfire;
        end
        if (fall || fbusy) begin
          fcnt  <= fn;
          fbusy <= (dly != '0) && !ffire;
        end
        if (rfire)      sw_q <= 1'b1;
        else if (ffire) sw_q <= 1'b0;
      end
    end

    assign sw_out[g] = (dly == '0) ? act[g] : sw_q;
  end

  assign tx_switch = sw_out[0];
  assign rx_switch = sw_out[1];
endmodule

// File: rtl/radar_pulse_seq_chk.sv
module radar_pulse_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [6:0] cfg_addr,
  input logic [31:0] cfg_data,
  input logic       cfg_we,
  input logic       tx_active,
  input logic       rx_window,
  input logic       pulse_start,
  input logic       tx_switch,
  input logic       rx_switch
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !tx_active && !rx_window && !pulse_start && !tx_switch && !rx_switch);

  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(tx_active && rx_window));

  p_start_in_on_r5: assert property (@(posedge clk) disable iff (rst)
    pulse_start |-> tx_active);

  p_start_single_r5: assert property (@(posedge clk) disable iff (rst)
    pulse_start |=> !pulse_start);

  p_on_rise_start_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_active) |-> pulse_start);

  p_hold_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 7'd0 && cfg_data[0]) |-> ##2
      (!tx_active && !rx_window && !pulse_start && !tx_switch && !rx_switch));
endmodule

bind radar_pulse_seq radar_pulse_seq_chk u_chk (.*);

// File: tb/test_radar_pulse_seq.sv
module test_radar_pulse_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic        cfg_we = 1'b0;
  logic tx_active, rx_window, pulse_start, tx_switch, rx_switch;

  int checks = 0, errors = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  bit tx_h[0:4095];
  bit rx_h[0:4095];

  radar_pulse_seq i_radar_pulse_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] outs();
    return {rx_switch, tx_switch, pulse_start, rx_window, tx_active};
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs {rxsw,txsw,start,rx,tx} actual=%b expected=%b at %0t",
               req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) check(tag_q.pop_front(), outs(), exp_q.pop_front());
  end

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_data = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_case(string tag, int on, int sw, int look, int idle,
                          int dtx, int drx, int n,
                          int w_at, int on2, int look2);
    int pstart = 0, con = on, csw = sw, clk_l = look, cid = idle;
    int per;
    wr(7'h00, 32'h1);
    repeat (3) @(negedge clk);
    check("R10 held before setup", outs(), 5'b0);
    wr(7'h01, 32'(on)); wr(7'h02, 32'(sw)); wr(7'h03, 32'(look));
    wr(7'h04, 32'(idle)); wr(7'h05, {16'(dtx), 16'(drx)});
    wr(7'h00, 32'h0);
    per = con + csw + clk_l + cid + 4;
    for (int t = 0; t < n; t++) begin
      int ofs;
      bit txa, rxa;
      logic [4:0] e;
      @(posedge clk);
      if (t - pstart == per) begin
        pstart = t;
        if (w_at >= 0 && w_at < t - 1) begin con = on2; clk_l = look2; end
        per = con + csw + clk_l + cid + 4;
      end
      ofs = t - pstart;
      txa = (ofs <= con);
      rxa = (ofs >= con + csw + 2) && (ofs < con + csw + clk_l + 3);
      tx_h[t] = txa; rx_h[t] = rxa;
      e[0] = txa; e[1] = rxa; e[2] = (ofs == 0);
      e[3] = (dtx == 0) ? txa : (t >= dtx ? tx_h[t-dtx] : 1'b0);
      e[4] = (drx == 0) ? rxa : (t >= drx ? rx_h[t-drx] : 1'b0);
      exp_q.push_back(e); tag_q.push_back(tag);
      if (t == w_at) begin
        #(CLK_PERIOD/4);
        cfg_addr = 7'h01; cfg_data = 32'(on2); cfg_we = 1'b1;
      end else if (t == w_at + 1) begin
        #(CLK_PERIOD/4);
        cfg_addr = 7'h03; cfg_data = 32'(look2);
      end else if (t == w_at + 2) begin
        #(CLK_PERIOD/4);
        cfg_we = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", outs(), 5'b0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check("R1 held after reset", outs(), 5'b0);
    wr(7'h00, 32'h0);
    repeat (6) @(negedge clk);
    check("R1 zero intervals run", {4'b0, tx_active}, {4'b0, 1'b0});

    run_case("R3 R4 R2", 3, 1, 4, 2, 2, 3, 60, -1, 0, 0);
    run_case("R9 R4", 0, 0, 0, 0, 0, 0, 24, -1, 0, 0);
    run_case("R7 R8", 9, 2, 6, 5, 12, 1, 120, -1, 0, 0);
    run_case("R8 R7 long rx", 4, 3, 2, 8, 3, 9, 100, -1, 0, 0);
    run_case("R6", 5, 1, 3, 2, 1, 2, 80, 2, 1, 6);

    run_case("R10 restart", 2, 0, 1, 1, 1, 1, 30, -1, 0, 0);
    wr(7'h00, 32'h1);
    @(negedge clk);
    check("R10 hold mid-run", outs(), 5'b0);
    repeat (10) @(negedge clk);
    check("R10 stays held", outs(), 5'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule